// File: doc/BRIEF.md
# Block-Transfer Address Stepping Unit

This unit is the address datapath of a bit-block move engine. It holds a 16-bit word address, a 4-bit stride, and two 6-bit bit offsets: one for the source and one for the destination. A 5-bit function code chooses which of these registers to load from a 16-bit input bus on the next clock edge. A single advance strobe moves all three position registers forward by the stride plus one in the same cycle. The word address wraps modulo 2^16, and each offset wraps modulo 64.

Two read selects drive a 16-bit result bus. One select returns the word address. The other returns both offsets packed into one word. A 3-bit dispatch code is always present on its own output. The sequencer uses it to branch: the code tells whether the transfer is in its special phase (address top bit set) and whether either offset has reached its last bit position.

Top module: `bbx_step_unit`

## Requirements
- R1: Function code 5'o33 loads all 16 bits of `din_i` into the word-address register on the clock edge.
- R2: Function code 5'o24 loads `din_i[3:0]` into the stride register.
- R3: Function code 5'o25 loads `din_i[5:0]` into the source offset, and function code 5'o26 loads the same bits into the destination offset.
- R4: While `adv_i` is high, the word address becomes address + stride + 1, modulo 65536.
- R5: While `adv_i` is high, the source offset and the destination offset each become offset + stride + 1, modulo 64.
- R6: Carries ripple through every bit of the address adder. For example, 16'h0FFF + 1 gives 16'h1000, and 16'hFFFF + 1 gives 16'h0000.
- R7: With `rd_ofs_i` high, `res_o[11:6]` carries the destination offset, `res_o[5:0]` carries the source offset, and `res_o[15:12]` is zero. With `rd_addr_i` high, `res_o` equals the address.
- R8: `disp_o` is 3 whenever address bit 15 is 0.
- R9: When address bit 15 is 1, `disp_o` is 7 minus the 2-bit value {source offset == 63, destination offset == 63}. The source flag is the high bit of that value.
- R10: When neither read select is high, `res_o` is zero. When both are high, the address is returned.
- R11: A synchronous active-high reset clears all four registers, which leaves `disp_o` at 3.
- R12: If a register is loaded in the same cycle as an advance, the load wins for that register and the other registers still advance. Any other function code loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| func_i | input | 5 | Function code selecting a register load |
| din_i | input | 16 | Load data bus |
| adv_i | input | 1 | Advance strobe: add stride + 1 to address and both offsets |
| rd_addr_i | input | 1 | Select the address onto the result bus |
| rd_ofs_i | input | 1 | Select the packed offsets onto the result bus |
| res_o | output | 16 | Result bus |
| disp_o | output | 3 | Dispatch code |

## Verification
The bench builds the unit with its default widths: a 16-bit address, a 4-bit stride and 6-bit offsets. At these widths the interactions can be swept exhaustively. Every stride is paired with every offset value, so both 6-bit adders are exercised across their whole wrap range. All 256 combinations of a 4-bit starting address and a stride are checked. A hex-digit carry sweep places runs of ones below each nibble, which makes the carry chain pass through every position up to the 16-bit overflow. All eight combinations of address top bit and the two last-position flags are reached for the dispatch code.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

    localparam int ADDR_W = 16;
    localparam int STEP_W = 4;
    localparam int OFS_W  = 6;
    localparam int FUNC_W = 5;
    localparam int DISP_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_IDLE    = 5'o00,
        FN_LD_STEP = 5'o24,
        FN_LD_SRC  = 5'o25,
        FN_LD_DST  = 5'o26,
        FN_LD_ADDR = 5'o33
    } func_e;

    typedef struct packed {
        logic addr;
        logic step;
        logic src;
        logic dst;
    } load_t;

    // Branch code: 3 outside the special phase, else 7 minus {src_last, dst_last}
    function automatic logic [DISP_W-1:0] disp_code(input logic phase,
                                                     input logic src_last,
                                                     input logic dst_last);
        if (!phase)
            return 3'd3;
        return 3'd7 - {1'b0, src_last, dst_last};
    endfunction

endpackage

// File: rtl/bbx_func_dec.sv
module bbx_func_dec
    import bbx_pkg::*;
#(
    parameter int FW = FUNC_W
) (
    input  logic [FW-1:0] func_i,
    output load_t         ld_o
);

    always_comb begin
        ld_o = '0;
        case (func_e'(func_i))
            FN_LD_ADDR: ld_o.addr = 1'b1;
            FN_LD_STEP: ld_o.step = 1'b1;
            FN_LD_SRC:  ld_o.src  = 1'b1;
            FN_LD_DST:  ld_o.dst  = 1'b1;
            default:    ld_o      = '0;
        endcase
    end

endmodule

// File: rtl/bbx_stride_add.sv
module bbx_stride_add #(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic [W-1:0]  acc_i,
    input  logic [SW-1:0] step_i,
    output logic [W-1:0]  sum_o
);

    // Wrap-around sum of accumulator, stride and the implicit one
    assign sum_o = acc_i + W'(step_i) + W'(1);

endmodule

// File: rtl/bbx_step_regs.sv
module bbx_step_regs
    import bbx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STEP_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  load_t         ld_i,
    input  logic [AW-1:0] din_i,
    input  logic          adv_i,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] step_o,
    output logic [OW-1:0] src_o,
    output logic [OW-1:0] dst_o
);

    localparam int N_OFS = 2;

    logic [AW-1:0] addr_r;
    logic [AW-1:0] addr_nxt;
    logic [SW-1:0] step_r;

    bbx_stride_add #(.W(AW), .SW(SW)) u_addr_add (
        .acc_i  (addr_r),
        .step_i (step_r),
        .sum_o  (addr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            addr_r <= '0;
        else if (ld_i.addr)
            addr_r <= din_i;
        else if (adv_i)
            addr_r <= addr_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_r <= '0;
        else if (ld_i.step)
            step_r <= din_i[SW-1:0];
    end

    // One offset lane per index: 0 = source, 1 = destination
    for (genvar g = 0; g < N_OFS; g++) begin : g_ofs
        logic [OW-1:0] q_r;
        logic [OW-1:0] nxt;
        logic          ld_this;

        assign ld_this = (g == 0) ? ld_i.src : ld_i.dst;

        bbx_stride_add #(.W(OW), .SW(SW)) u_add (
            .acc_i  (q_r),
            .step_i (step_r),
            .sum_o  (nxt)
        );

        always_ff @(posedge clk) begin
            if (rst)
                q_r <= '0;
            else if (ld_this)
                q_r <= din_i[OW-1:0];
            else if (adv_i)
                q_r <= nxt;
        end
    end

    assign addr_o = addr_r;
    assign step_o = step_r;
    assign src_o  = g_ofs[0].q_r;
    assign dst_o  = g_ofs[1].q_r;

endmodule

// File: rtl/bbx_readout.sv
module bbx_readout
    import bbx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [OW-1:0]     src_i,
    input  logic [OW-1:0]     dst_i,
    input  logic              rd_addr_i,
    input  logic              rd_ofs_i,
    output logic [AW-1:0]     res_o,
    output logic [DISP_W-1:0] disp_o
);

    localparam int PACK_W = 2 * OW;

    always_comb begin
        res_o = '0;
        if (rd_addr_i) begin
            res_o = addr_i;
        end else if (rd_ofs_i) begin
            res_o[PACK_W-1:OW] = dst_i;
            res_o[OW-1:0]      = src_i;
        end
    end

    assign disp_o = disp_code(addr_i[AW-1], &src_i, &dst_i);

endmodule

// File: rtl/bbx_step_unit.sv
module bbx_step_unit
    import bbx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STEP_W,
    parameter int OW = OFS_W,
    parameter int FW = FUNC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FW-1:0]     func_i,
    input  logic [AW-1:0]     din_i,
    input  logic              adv_i,
    input  logic              rd_addr_i,
    input  logic              rd_ofs_i,
    output logic [AW-1:0]     res_o,
    output logic [DISP_W-1:0] disp_o
);

    load_t         ld;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] step_q;
    logic [OW-1:0] src_q;
    logic [OW-1:0] dst_q;

    bbx_func_dec #(.FW(FW)) u_dec (
        .func_i (func_i),
        .ld_o   (ld)
    );

    bbx_step_regs #(.AW(AW), .SW(SW), .OW(OW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .ld_i   (ld),
        .din_i  (din_i),
        .adv_i  (adv_i),
        .addr_o (addr_q),
        .step_o (step_q),
        .src_o  (src_q),
        .dst_o  (dst_q)
    );

    bbx_readout #(.AW(AW), .OW(OW)) u_rd (
        .addr_i    (addr_q),
        .src_i     (src_q),
        .dst_i     (dst_q),
        .rd_addr_i (rd_addr_i),
        .rd_ofs_i  (rd_ofs_i),
        .res_o     (res_o),
        .disp_o    (disp_o)
    );

endmodule

// File: rtl/bbx_step_chk.sv
module bbx_step_chk
    import bbx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STEP_W,
    parameter int OW = OFS_W,
    parameter int FW = FUNC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [FW-1:0]     func_i,
    input logic [AW-1:0]     din_i,
    input logic              adv_i,
    input logic              rd_addr_i,
    input logic              rd_ofs_i,
    input logic [AW-1:0]     res_o,
    input logic [DISP_W-1:0] disp_o,
    input logic [AW-1:0]     addr_q,
    input logic [SW-1:0]     step_q,
    input logic [OW-1:0]     src_q,
    input logic [OW-1:0]     dst_q
);

    logic [AW-1:0] a_stride;
    logic [OW-1:0] o_stride;
    assign a_stride = AW'(step_q) + AW'(1);
    assign o_stride = OW'(step_q) + OW'(1);

    // R1
    ld_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (func_i == FW'(FN_LD_ADDR)) |=> (addr_q == $past(din_i)));

    // R2
    ld_step_chk: assert property (@(posedge clk) disable iff (rst)
        (func_i == FW'(FN_LD_STEP)) |=> (step_q == $past(din_i[SW-1:0])));

    // R3
    ld_src_chk: assert property (@(posedge clk) disable iff (rst)
        (func_i == FW'(FN_LD_SRC)) |=> (src_q == $past(din_i[OW-1:0])));

    // R4
    adv_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && func_i != FW'(FN_LD_ADDR)) |=>
            (AW'(addr_q - $past(addr_q)) == $past(a_stride)));

    // R5
    adv_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && func_i != FW'(FN_LD_DST)) |=>
            (OW'(dst_q - $past(dst_q)) == $past(o_stride)));

    // R8
    disp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_q[AW-1] |-> (disp_o == 3'd3));

    // R10
    rd_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_addr_i && !rd_ofs_i) |-> (res_o == '0));

    // R11
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && step_q == '0 && src_q == '0 && dst_q == '0));

endmodule

bind bbx_step_unit bbx_step_chk #(.AW(AW), .SW(SW), .OW(OW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .func_i    (func_i),
    .din_i     (din_i),
    .adv_i     (adv_i),
    .rd_addr_i (rd_addr_i),
    .rd_ofs_i  (rd_ofs_i),
    .res_o     (res_o),
    .disp_o    (disp_o),
    .addr_q    (addr_q),
    .step_q    (step_q),
    .src_q     (src_q),
    .dst_q     (dst_q)
);

// File: tb/sim_bbx_step_unit.sv
module sim_bbx_step_unit;

    localparam logic [4:0] F_IDLE = 5'o00;
    localparam logic [4:0] F_STEP = 5'o24;
    localparam logic [4:0] F_SRC  = 5'o25;
    localparam logic [4:0] F_DST  = 5'o26;
    localparam logic [4:0] F_ADDR = 5'o33;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  func = F_IDLE;
    logic [15:0] din = '0;
    logic        adv = 1'b0;
    logic        rsel_a = 1'b0;
    logic        rsel_o = 1'b0;
    logic [15:0] res;
    logic [2:0]  disp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bbx_step_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .func_i    (func),
        .din_i     (din),
        .adv_i     (adv),
        .rd_addr_i (rsel_a),
        .rd_ofs_i  (rsel_o),
        .res_o     (res),
        .disp_o    (disp)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input logic [4:0] f, input logic [15:0] d, input logic a);
        @(negedge clk);
        func = f;
        din  = d;
        adv  = a;
        @(posedge clk);
        #1;
        func = F_IDLE;
        adv  = 1'b0;
    endtask

    task automatic rd_addr(output logic [15:0] v);
        rsel_a = 1'b1;
        rsel_o = 1'b0;
        #1;
        v = res;
        rsel_a = 1'b0;
        #1;
    endtask

    task automatic rd_ofs(output logic [15:0] v);
        rsel_a = 1'b0;
        rsel_o = 1'b1;
        #1;
        v = res;
        rsel_o = 1'b0;
        #1;
    endtask

    function automatic logic [15:0] pack(input int d, input int s);
        return 16'(((d & 63) << 6) | (s & 63));
    endfunction

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R11 reset state
        rd_addr(v);  check("R11 addr after reset", v, 16'h0000);
        rd_ofs(v);   check("R11 offsets after reset", v, 16'h0000);
        check("R11 disp after reset", 16'(disp), 16'd3);

        // R10 idle result bus
        op(F_ADDR, 16'hBEEF, 1'b0);
        #1; check("R10 no select", res, 16'h0000);

        // R1 / R7 walking ones on address
        for (int i = 0; i < 16; i++) begin
            op(F_ADDR, 16'(1 << i), 1'b0);
            rd_addr(v);
            check("R1 address load", v, 16'(1 << i));
        end

        // R3 / R7 walking ones on offsets
        for (int i = 0; i < 6; i++) begin
            op(F_SRC, 16'hFFC0 | 16'(1 << i), 1'b0);
            op(F_DST, 16'(1 << i), 1'b0);
            rd_ofs(v);
            check("R3 offset loads", v, pack(1 << i, 1 << i));
            op(F_DST, 16'h0000, 1'b0);
            rd_ofs(v);
            check("R7 source packing", v, pack(0, 1 << i));
        end

        // R2 / R4 address + stride + 1 sweep
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                op(F_ADDR, 16'(i), 1'b0);
                op(F_STEP, 16'hFFF0 | 16'(j), 1'b0);
                op(F_IDLE, 16'h0, 1'b1);
                rd_addr(v);
                check("R4 address advance", v, 16'(i + j + 1));
            end
        end

        // R5 offset wrap sweep, every stride against every offset
        for (int s = 0; s < 16; s++) begin
            op(F_STEP, 16'(s), 1'b0);
            for (int o = 0; o < 64; o++) begin
                int dv;
                dv = (o * 5 + s) & 63;
                op(F_SRC, 16'(o), 1'b0);
                op(F_DST, 16'(dv), 1'b0);
                op(F_IDLE, 16'h0, 1'b1);
                rd_ofs(v);
                check("R5 offset advance", v, pack(dv + s + 1, o + s + 1));
            end
        end

        // R6 carry ripple per hex digit
        op(F_STEP, 16'h0000, 1'b0);
        for (int i = 0; i <= 12; i += 4) begin
            for (int j = 0; j < 16; j++) begin
                op(F_ADDR, 16'((j << i) | ((1 << i) - 1)), 1'b0);
                op(F_IDLE, 16'h0, 1'b1);
                rd_addr(v);
                check("R6 carry ripple", v, 16'((j + 1) << i));
            end
        end

        // R8 / R9 dispatch code over all flag combinations
        for (int i = 0; i < 8; i++) begin
            int ex;
            op(F_ADDR, 16'(((i >> 2) & 1) << 15), 1'b0);
            op(F_SRC, ((i >> 1) & 1) != 0 ? 16'h003F : 16'h0000, 1'b0);
            op(F_DST, (i & 1) != 0 ? 16'h003F : 16'h0000, 1'b0);
            ex = ((i >> 2) & 1) != 0 ? 7 - (i & 3) : 3;
            #1;
            check(((i >> 2) & 1) != 0 ? "R9 dispatch" : "R8 dispatch", 16'(disp), 16'(ex));
        end

        // R10 both selects: address wins
        op(F_ADDR, 16'h5A5A, 1'b0);
        rsel_a = 1'b1; rsel_o = 1'b1; #1;
        check("R10 both selects", res, 16'h5A5A);
        rsel_a = 1'b0; rsel_o = 1'b0; #1;

        // R12 load beats advance per register
        op(F_STEP, 16'd2, 1'b0);
        op(F_SRC, 16'd10, 1'b0);
        op(F_DST, 16'd20, 1'b0);
        op(F_ADDR, 16'h0100, 1'b1);
        rd_addr(v); check("R12 address load wins", v, 16'h0100);
        rd_ofs(v);  check("R12 offsets advance", v, pack(23, 13));
        op(F_SRC, 16'd5, 1'b1);
        rd_ofs(v);  check("R12 source load wins", v, pack(26, 5));
        rd_addr(v); check("R12 address advances", v, 16'h0103);
        op(5'o17, 16'hFFFF, 1'b0);
        rd_addr(v); check("R12 unused code address", v, 16'h0103);
        rd_ofs(v);  check("R12 unused code offsets", v, pack(26, 5));

        // R11 reset mid-run, stride cleared too
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        rd_addr(v); check("R11 addr cleared", v, 16'h0000);
        rd_ofs(v);  check("R11 offsets cleared", v, 16'h0000);
        op(F_IDLE, 16'h0, 1'b1);
        rd_addr(v); check("R11 stride cleared", v, 16'h0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule